// File: doc/BRIEF.md
# Physical Memory Protection Priority Match Checker

This purely combinational block decides whether one memory access may proceed under a table of protection entries. It receives the access byte address, the access size in bytes, the access kind (read, write or execute) and the privilege level of the requester. It also receives the configuration byte and the address word of every protection entry, as held by the control-register file.

Each entry classifies the access as pass, deny or continue. The entries are scanned from the lowest index upward, and the first entry that does not say continue settles the result. An access that no entry claims is refused. The outcome is a single access-fault flag that a trap unit can consume.

The protection granule is fixed at four bytes. Entry address words therefore hold byte addresses divided by four.

Top module: `pmp_match_checker`

## Requirements
- R1: Entries are evaluated with index 0 having the highest priority. The lowest-indexed entry whose verdict is pass or deny decides the outcome, and every entry above it has no effect.
- R2: Configuration bits [4:3] select the match kind: 0 off, 1 top-of-range, 2 single aligned 4-byte word, 3 naturally aligned power-of-two region. An off entry always yields continue, whatever its other bits are.
- R3: A top-of-range entry i covers byte addresses from (word of entry i-1)*4 inclusive to (word of entry i)*4 exclusive. Entry 0 uses 0 as its lower bound. When the lower bound is not below the upper bound, the entry matches nothing.
- R4: A single-word entry covers the 4 bytes starting at word*4.
- R5: For a power-of-two entry whose word has k trailing one bits, the region is 2^(k+3) bytes in size. Its base is the word with its low k+1 bits cleared, multiplied by 4.
- R6: An access that overlaps an entry's region but is not fully contained in it yields deny.
- R7: For a fully contained access, the permission bit for the kind is consulted: bit 0 for read (kind code 0), bit 1 for write (code 1), bit 2 for execute (code 2). Pass if the bit is set, deny otherwise.
- R8: For machine privilege (code 3), a contained access passes when the entry's lock bit (bit 7) is clear. The permission bits apply only when the lock bit is set. Privilege codes 0 and 1 always have the permission bits applied.
- R9: When every entry yields continue, the access is refused, at any privilege.
- R10: Regions are half-open. The byte at an entry's upper limit is outside it, and `access_fault_o` is 1 exactly when the access is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| access_addr_i | input | XLEN | Byte address of the first byte accessed |
| access_bytes_i | input | WIDTH_W | Number of bytes accessed (1 or more) |
| access_kind_i | input | 2 | 0 read, 1 write, 2 execute |
| access_priv_i | input | 2 | Privilege level, 3 is machine |
| entry_cfg_i | input | 8*NUM_ENTRIES | Configuration byte of entry i at bits [8i+7:8i] |
| entry_addr_i | input | XLEN*NUM_ENTRIES | Address word (byte address / 4) of entry i at [XLEN*i +: XLEN] |
| access_fault_o | output | 1 | 1 when the access is refused |

## Verification
The bench sets up two entries with different verdicts over the same bytes. A chain that picked the wrong winner would flip the fault flag. It also probes the byte just past each region's limit, where a closed-range compare would wrongly grant access. Separate probes cover an inverted top-of-range pair that must match nothing and a power-of-two word whose trailing ones set the size, where an off-by-one mask would halve or double the region. Accesses that straddle a region edge must be refused. Machine-mode accesses are checked with the lock bit both clear and set, since a design that ignored the lock would wrongly deny or wrongly allow them.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    VD_CONT = 2'd0,
    VD_PASS = 2'd1,
    VD_DENY = 2'd2
  } verdict_e;

  localparam logic [1:0] MODE_OFF   = 2'd0;
  localparam logic [1:0] MODE_TOR   = 2'd1;
  localparam logic [1:0] MODE_NA4   = 2'd2;
  localparam logic [1:0] MODE_NAPOT = 2'd3;

  localparam logic [1:0] PRIV_MACHINE = 2'd3;

  localparam int CFG_LOCK_BIT = 7;

  // permission bit selected by the access kind (0 read, 1 write, 2 execute)
  function automatic logic kind_allowed(logic [2:0] perm, logic [1:0] kind);
    case (kind)
      2'd0:    return perm[0];
      2'd1:    return perm[1];
      2'd2:    return perm[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pmp_entry_eval.sv
module pmp_entry_eval
  import pmp_chk_pkg::*;
#(
  parameter int XLEN = 32,
  localparam int RW  = XLEN + 3
) (
  input  logic [1:0]      mode_i,
  input  logic [2:0]      perm_i,
  input  logic            lock_i,
  input  logic [XLEN-1:0] word_i,
  input  logic [XLEN-1:0] prev_word_i,
  input  logic [RW-1:0]   acc_lo_i,
  input  logic [RW-1:0]   acc_hi_i,
  input  logic [1:0]      kind_i,
  input  logic            machine_i,
  output verdict_e        verdict_o,
  output logic            overlap_o,
  output logic            inside_o
);

  function automatic logic [RW-1:0] word_to_byte(logic [XLEN-1:0] w);
    return {1'b0, w, 2'b00};
  endfunction

  // mask of the trailing ones plus the first zero above them
  function automatic logic [XLEN-1:0] napot_mask(logic [XLEN-1:0] w);
    return w ^ (w + 1'b1);
  endfunction

  function automatic logic [RW-1:0] napot_size(logic [XLEN-1:0] m);
    logic [XLEN:0] words;
    words = {1'b0, m} + 1'b1;
    return {words, 2'b00};
  endfunction

  logic [RW-1:0]   reg_lo, reg_hi;
  logic            reg_valid;
  logic [XLEN-1:0] low_mask;

  always_comb begin
    low_mask  = napot_mask(word_i);
    reg_lo    = '0;
    reg_hi    = '0;
    reg_valid = 1'b0;
    case (mode_i)
      MODE_TOR: begin
        reg_lo    = word_to_byte(prev_word_i);
        reg_hi    = word_to_byte(word_i);
        reg_valid = reg_lo < reg_hi;
      end
      MODE_NA4: begin
        reg_lo    = word_to_byte(word_i);
        reg_hi    = reg_lo + RW'(4);
        reg_valid = 1'b1;
      end
      MODE_NAPOT: begin
        reg_lo    = word_to_byte(word_i & ~low_mask);
        reg_hi    = reg_lo + napot_size(low_mask);
        reg_valid = 1'b1;
      end
      default: reg_valid = 1'b0;
    endcase
  end

  assign overlap_o = reg_valid && (acc_lo_i < reg_hi) && (acc_hi_i > reg_lo);
  assign inside_o  = reg_valid && (acc_lo_i >= reg_lo) && (acc_hi_i <= reg_hi);

  always_comb begin
    if (!overlap_o)                verdict_o = VD_CONT;
    else if (!inside_o)            verdict_o = VD_DENY;
    else if (machine_i && !lock_i) verdict_o = VD_PASS;
    else if (kind_allowed(perm_i, kind_i)) verdict_o = VD_PASS;
    else                           verdict_o = VD_DENY;
  end

endmodule

// File: rtl/pmp_prio_chain.sv
module pmp_prio_chain
  import pmp_chk_pkg::*;
#(
  parameter int N      = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  verdict_e         vd_i [N],
  output logic [N-1:0]     first_hit_o,
  output logic             decided_o,
  output logic             grant_o,
  output logic [IDX_W-1:0] win_idx_o
);

  logic [N:0]   seen;
  logic [N-1:0] pass_vec;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    assign seen[i+1]      = seen[i] | (vd_i[i] != VD_CONT);
    assign first_hit_o[i] = !seen[i] && (vd_i[i] != VD_CONT);
    assign pass_vec[i]    = (vd_i[i] == VD_PASS);
  end

  assign decided_o = seen[N];
  assign grant_o   = |(first_hit_o & pass_vec);

  always_comb begin
    win_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (first_hit_o[i]) win_idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/pmp_match_checker.sv
module pmp_match_checker
  import pmp_chk_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int WIDTH_W     = 4,
  localparam int RW         = XLEN + 3,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic [XLEN-1:0]             access_addr_i,
  input  logic [WIDTH_W-1:0]          access_bytes_i,
  input  logic [1:0]                  access_kind_i,
  input  logic [1:0]                  access_priv_i,
  input  logic [8*NUM_ENTRIES-1:0]    entry_cfg_i,
  input  logic [XLEN*NUM_ENTRIES-1:0] entry_addr_i,
  output logic                        access_fault_o
);

  logic [RW-1:0]          acc_lo, acc_hi;
  logic                   machine;
  verdict_e               entry_verdict [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entry_overlap;
  logic [NUM_ENTRIES-1:0] entry_inside;
  logic [NUM_ENTRIES-1:0] first_hit;
  logic                   chain_decided;
  logic                   chain_grant;
  logic [IDX_W-1:0]       win_idx;

  assign acc_lo  = RW'(access_addr_i);
  assign acc_hi  = acc_lo + RW'(access_bytes_i);
  assign machine = (access_priv_i == PRIV_MACHINE);

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_entry
    logic [XLEN-1:0] prev_word;
    if (i == 0) begin : g_first
      assign prev_word = '0;
    end else begin : g_rest
      assign prev_word = entry_addr_i[XLEN*(i-1) +: XLEN];
    end

    pmp_entry_eval #(.XLEN(XLEN)) u_eval (
      .mode_i      (entry_cfg_i[8*i+3 +: 2]),
      .perm_i      (entry_cfg_i[8*i +: 3]),
      .lock_i      (entry_cfg_i[8*i+CFG_LOCK_BIT]),
      .word_i      (entry_addr_i[XLEN*i +: XLEN]),
      .prev_word_i (prev_word),
      .acc_lo_i    (acc_lo),
      .acc_hi_i    (acc_hi),
      .kind_i      (access_kind_i),
      .machine_i   (machine),
      .verdict_o   (entry_verdict[i]),
      .overlap_o   (entry_overlap[i]),
      .inside_o    (entry_inside[i])
    );
  end

  pmp_prio_chain #(.N(NUM_ENTRIES)) u_chain (
    .vd_i        (entry_verdict),
    .first_hit_o (first_hit),
    .decided_o   (chain_decided),
    .grant_o     (chain_grant),
    .win_idx_o   (win_idx)
  );

  assign access_fault_o = !chain_grant;

endmodule

// File: rtl/pmp_match_checker_sva.sv
module pmp_match_checker_sva
  import pmp_chk_pkg::*;
#(
  parameter int N      = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input logic             fault_i,
  input verdict_e         verdict_i [N],
  input logic [N-1:0]     first_hit_i,
  input logic             decided_i,
  input logic [IDX_W-1:0] win_idx_i,
  input logic [8*N-1:0]   cfg_i,
  input logic [N-1:0]     overlap_i,
  input logic [N-1:0]     inside_i,
  input logic             machine_i
);

  always_comb begin
    assert_single_winner_R1: assert ($onehot0(first_hit_i))
      else $error("more than one deciding entry");
    if (!decided_i) begin
      assert_fall_through_denied_R9: assert (fault_i)
        else $error("undecided access granted");
    end else begin
      assert_winner_sets_fault_R10: assert (fault_i == (verdict_i[win_idx_i] == VD_DENY))
        else $error("fault flag disagrees with winning entry");
    end
    for (int i = 0; i < N; i++) begin
      if (cfg_i[8*i+3 +: 2] == MODE_OFF) begin
        assert_off_entry_continues_R2: assert (verdict_i[i] == VD_CONT)
          else $error("off entry %0d gave a verdict", i);
      end
      if (overlap_i[i] && !inside_i[i]) begin
        assert_straddle_denied_R6: assert (verdict_i[i] == VD_DENY)
          else $error("straddling access not denied by entry %0d", i);
      end
      if (inside_i[i] && machine_i && !cfg_i[8*i+CFG_LOCK_BIT]) begin
        assert_machine_unlocked_pass_R8: assert (verdict_i[i] == VD_PASS)
          else $error("unlocked entry %0d refused machine access", i);
      end
    end
  end

endmodule

bind pmp_match_checker pmp_match_checker_sva #(.N(NUM_ENTRIES)) u_sva (
  .fault_i     (access_fault_o),
  .verdict_i   (entry_verdict),
  .first_hit_i (first_hit),
  .decided_i   (chain_decided),
  .win_idx_i   (win_idx),
  .cfg_i       (entry_cfg_i),
  .overlap_i   (entry_overlap),
  .inside_i    (entry_inside),
  .machine_i   (machine)
);

// File: tb/pmp_match_checker_tb.sv
module pmp_match_checker_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NE   = 16;
  localparam int XL   = 32;
  localparam int WW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [XL-1:0]    addr;
  logic [WW-1:0]    nbytes;
  logic [1:0]       kind;
  logic [1:0]       priv;
  logic [8*NE-1:0]  cfg_bus;
  logic [XL*NE-1:0] word_bus;
  logic             fault;

  logic [7:0]    cfg  [NE];
  logic [XL-1:0] word [NE];

  int checks = 0;
  int errors = 0;

  pmp_match_checker #(.NUM_ENTRIES(NE), .XLEN(XL), .WIDTH_W(WW)) u_dut (
    .access_addr_i  (addr),
    .access_bytes_i (nbytes),
    .access_kind_i  (kind),
    .access_priv_i  (priv),
    .entry_cfg_i    (cfg_bus),
    .entry_addr_i   (word_bus),
    .access_fault_o (fault)
  );

  // byte membership, written per byte rather than as range bounds
  function automatic bit byte_in(int e, longint b);
    longint w, lo, lowm;
    int k;
    w = b >>> 2;
    case (cfg[e][4:3])
      2'd1: begin
        lo = (e == 0) ? 0 : longint'(word[e-1]);
        return (w >= lo) && (w < longint'(word[e]));
      end
      2'd2: return w == longint'(word[e]);
      2'd3: begin
        k = 0;
        while (k < XL && word[e][k]) k++;
        lowm = (longint'(1) << (k + 1)) - 1;
        return (w | lowm) == (longint'(word[e]) | lowm);
      end
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit expect_fault(longint a, int n, int kd, int pv);
    int hits;
    for (int e = 0; e < NE; e++) begin
      hits = 0;
      for (int b = 0; b < n; b++) if (byte_in(e, a + b)) hits++;
      if (hits == 0) continue;
      if (hits != n) return 1'b1;
      if (pv == 3 && !cfg[e][7]) return 1'b0;
      return !cfg[e][kd];
    end
    return 1'b1;
  endfunction

  task automatic clear_table();
    for (int e = 0; e < NE; e++) begin
      cfg[e]  = 8'h00;
      word[e] = '0;
    end
  endtask

  task automatic probe(string tag, longint a, int n, int kd, int pv, bit want);
    bit mdl;
    @(negedge clk);
    for (int e = 0; e < NE; e++) begin
      cfg_bus[8*e +: 8]   = cfg[e];
      word_bus[XL*e +: XL] = word[e];
    end
    addr   = a[XL-1:0];
    nbytes = WW'(n);
    kind   = 2'(kd);
    priv   = 2'(pv);
    #(CLK_PERIOD/4);
    mdl = expect_fault(a, n, kd, pv);
    checks++;
    if (mdl != want) begin
      errors++;
      $display("FAIL %s bench model=%0d directed=%0d", tag, mdl, want);
    end
    checks++;
    if (fault !== want) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, fault, want);
    end
  endtask

  task automatic probe_rand(longint a, int n, int kd, int pv);
    bit want;
    want = expect_fault(a, n, kd, pv);
    probe("R1 R10 random", a, n, kd, pv, want);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
    clear_table();
    addr = '0; nbytes = '0; kind = '0; priv = '0; cfg_bus = '0; word_bus = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // R9: empty table refuses everything, even machine mode
    probe("R9 empty table machine", 64'h40, 4, 0, 3, 1'b1);
    probe("R9 empty table user", 64'h0, 1, 2, 0, 1'b1);

    // R3 R7: entry 0 TOR with word 0x10 covers bytes 0x00..0x3F
    clear_table();
    cfg[0] = 8'h09; word[0] = 32'h10;
    probe("R3 tor entry0 inside", 64'h3C, 4, 0, 0, 1'b0);
    probe("R3 tor entry0 base zero", 64'h0, 1, 0, 1, 1'b0);
    probe("R10 byte at limit excluded", 64'h40, 1, 0, 0, 1'b1);
    probe("R6 straddle tor limit", 64'h3E, 4, 0, 0, 1'b1);
    probe("R7 write without W bit", 64'h10, 4, 1, 0, 1'b1);

    // R3: inverted TOR pair matches nothing
    clear_table();
    word[0] = 32'h20;
    cfg[1] = 8'h0F; word[1] = 32'h10;
    probe("R3 inverted tor no match", 64'h50, 4, 0, 0, 1'b1);

    // R4: single word at 0x80..0x83
    clear_table();
    cfg[3] = 8'h12; word[3] = 32'h20;
    probe("R4 na4 write ok", 64'h80, 4, 1, 0, 1'b0);
    probe("R4 na4 next word", 64'h84, 1, 1, 0, 1'b1);
    probe("R6 na4 straddle", 64'h82, 4, 1, 0, 1'b1);

    // R5: word 0x47 has 3 trailing ones -> 64 bytes at 0x100
    clear_table();
    cfg[5] = 8'h1C; word[5] = 32'h47;
    probe("R5 napot last word exec", 64'h13C, 4, 2, 1, 1'b0);
    probe("R5 napot base", 64'h100, 8, 2, 1, 1'b0);
    probe("R5 napot past end", 64'h140, 1, 2, 1, 1'b1);
    probe("R5 napot below base", 64'hFC, 4, 2, 1, 1'b1);

    // R1: lower index wins over a later entry on the same bytes
    clear_table();
    cfg[2] = 8'h10; word[2] = 32'h30;
    cfg[5] = 8'h17; word[5] = 32'h30;
    probe("R1 deny at 2 beats pass at 5", 64'hC0, 4, 0, 0, 1'b1);
    cfg[2] = 8'h17; cfg[5] = 8'h10;
    probe("R1 pass at 2 beats deny at 5", 64'hC0, 4, 0, 0, 1'b0);

    // R2: off entry with all perms is ignored
    clear_table();
    cfg[4] = 8'h07; word[4] = 32'h30;
    probe("R2 off entry ignored", 64'hC0, 4, 0, 3, 1'b1);

    // R8: machine mode and lock
    clear_table();
    cfg[6] = 8'h10; word[6] = 32'h30;
    probe("R8 machine unlocked passes", 64'hC0, 4, 1, 3, 1'b0);
    probe("R8 user same entry denied", 64'hC0, 4, 1, 0, 1'b1);
    cfg[6] = 8'h90;
    probe("R8 machine locked denied", 64'hC0, 4, 1, 3, 1'b1);
    cfg[6] = 8'h92;
    probe("R8 machine locked with W", 64'hC0, 4, 1, 3, 1'b0);

    // random mix checked against the bench model
    for (int v = 0; v < 1500; v++) begin
      int wsel;
      int pv;
      if (v % 12 == 0) begin
        for (int e = 0; e < NE; e++) begin
          cfg[e]  = 8'($urandom_range(0, 255)) & 8'h9F;
          word[e] = XL'($urandom_range(0, 160));
        end
      end
      wsel = $urandom_range(0, 3);
      pv = $urandom_range(0, 2);
      if (pv == 2) pv = 3;
      probe_rand(longint'($urandom_range(0, 700)), 1 << wsel,
                 $urandom_range(0, 2), pv);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule